// File: doc/BRIEF.md
# Translation Buffer Entry Manager

This block holds a small, fully associative translation buffer: a set of slots, each with a tag word and a translation word. A host drives it with one command per cycle through a single command port. The commands load an internal tag-holding register, insert an entry automatically, write an entry at a chosen slot, search for a tag, or invalidate every slot. Each write to a slot takes its tag from the tag-holding register and its translation word from the command data. Address translation on the memory path and demap operations are handled elsewhere.

An automatic insert picks its slot in two passes. The first pass takes the lowest-numbered slot whose translation word has its valid bit clear. If every slot is valid, the second pass takes the lowest-numbered slot whose lock bit is clear. If every slot is valid and locked, the insert is dropped and reported as failed. A search returns the lowest-numbered slot that is valid and whose tag equals the supplied key. Both searches are priority scans done in the same cycle as the command, and the response is registered.

Top module: `tlbm_entry_mgr`

## Requirements
- R1: After reset no slot is valid, the tag-holding register is zero, and rsp_valid is low.
- R2: Command code 0 (load tag) stores cmd_data in the tag-holding register. Every later slot write copies the current value of that register into the slot's tag.
- R3: Command code 1 (insert) writes the lowest-numbered slot whose valid bit (translation word bit VALID_BIT, default 63) is clear, if any such slot exists. rsp_ok is 1 and rsp_slot gives the slot.
- R4: When every slot is valid, an insert writes the lowest-numbered slot whose lock bit (translation word bit LOCK_BIT, default 6) is clear.
- R5: When every slot is both valid and locked, an insert changes no slot and responds with rsp_ok 0 and rsp_slot 0.
- R6: Command code 2 (indexed write) writes the slot numbered by cmd_addr bits [IDX_LSB+IDX_W-1:IDX_LSB] (default [8:3]), whether or not that slot is locked, ignores all other address bits, and responds with rsp_ok 1 and that slot number.
- R7: Command code 3 (search) responds with rsp_ok 1, rsp_data equal to the tag, and rsp_slot equal to the lowest-numbered slot that is valid and whose tag equals cmd_data. Invalid slots never match.
- R8: A search with no match responds with rsp_ok 0, rsp_data 0 and rsp_slot 0.
- R9: Every command is answered by rsp_valid high exactly one cycle later, and rsp_valid is low in every other cycle. Command codes 5 to 7 change nothing and respond with rsp_ok 0. rsp_data is 0 for every command except a search that hits.
- R10: Command code 4 (clear) clears the valid bit of every slot, keeps the tag-holding register, and responds with rsp_ok 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Command code (0 load tag, 1 insert, 2 indexed write, 3 search, 4 clear) |
| cmd_addr | input | ADDR_W | Address; carries the slot number for an indexed write |
| cmd_data | input | WORD_W | Tag value, translation word or search key |
| rsp_valid | output | 1 | Response for the previous cycle's command |
| rsp_ok | output | 1 | Insert landed, search hit, or other command accepted |
| rsp_data | output | WORD_W | Matching tag on a search hit, zero otherwise |
| rsp_slot | output | IDX_W | Slot written or found |

## Verification
The bench builds the block with 8 slots, 16-bit words, the valid bit at bit 15 and the lock bit at bit 6, with the slot number still taken from address bits [5:3]. At that size every slot can be filled, locked, invalidated and searched by a short command stream. This covers the full-table cases, where the insert falls back to the lock pass or is dropped. It also covers duplicate tags across slots, which test search priority. After every phase a search is made for each slot's tag, and each is compared with a bench model.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;

    typedef enum logic [2:0] {
        OP_LOAD_TAG  = 3'd0,
        OP_INSERT    = 3'd1,
        OP_WRITE_IDX = 3'd2,
        OP_SEARCH    = 3'd3,
        OP_CLEAR     = 3'd4
    } tlbm_op_e;

endpackage

// File: rtl/tlbm_first_set.sv
module tlbm_first_set #(
    parameter int W  = 64,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top down so the lowest set bit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tlbm_victim_pick.sv
module tlbm_victim_pick #(
    parameter int N  = 64,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  valid_vec,
    input  logic [N-1:0]  lock_vec,
    output logic          pick_ok,
    output logic [IW-1:0] pick_slot
);
    logic          free_found;
    logic [IW-1:0] free_slot;
    logic          unlk_found;
    logic [IW-1:0] unlk_slot;

    // Pass one: any slot not holding a valid entry.
    tlbm_first_set #(.W(N), .IW(IW)) u_free (
        .req   (~valid_vec),
        .found (free_found),
        .idx   (free_slot)
    );

    // Pass two: any slot whose entry may be displaced.
    tlbm_first_set #(.W(N), .IW(IW)) u_unlk (
        .req   (~lock_vec),
        .found (unlk_found),
        .idx   (unlk_slot)
    );

    always_comb begin
        pick_ok   = free_found | unlk_found;
        pick_slot = free_found ? free_slot : (unlk_found ? unlk_slot : '0);
    end
endmodule

// File: rtl/tlbm_tag_match.sv
module tlbm_tag_match #(
    parameter int N = 64,
    parameter int W = 64
) (
    input  logic [N-1:0][W-1:0] tags,
    input  logic [N-1:0]        valid_vec,
    input  logic [W-1:0]        key,
    output logic [N-1:0]        hit_vec
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = valid_vec[g] && (tags[g] == key);
    end
endmodule

// File: rtl/tlbm_entry_mgr.sv
module tlbm_entry_mgr #(
    parameter int NUM_ENTRIES = 64,
    parameter int WORD_W      = 64,
    parameter int ADDR_W      = 64,
    parameter int VALID_BIT   = 63,
    parameter int LOCK_BIT    = 6,
    parameter int IDX_LSB     = 3,
    localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [WORD_W-1:0] cmd_data,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [WORD_W-1:0] rsp_data,
    output logic [IDX_W-1:0]  rsp_slot
);
    import tlbm_pkg::*;

    typedef struct packed {
        logic [NUM_ENTRIES-1:0][WORD_W-1:0] tag;
        logic [NUM_ENTRIES-1:0][WORD_W-1:0] data;
        logic [WORD_W-1:0]                  tacc;
        logic                               rsp_valid;
        logic                               rsp_ok;
        logic [WORD_W-1:0]                  rsp_data;
        logic [IDX_W-1:0]                   rsp_slot;
        logic [2:0]                         rsp_op;
    } state_t;

    state_t s_d, s_q;

    logic [NUM_ENTRIES-1:0] valid_vec;
    logic [NUM_ENTRIES-1:0] lock_vec;
    logic [NUM_ENTRIES-1:0] hit_vec;
    logic                   vic_ok;
    logic [IDX_W-1:0]       vic_slot;
    logic                   hit_found;
    logic [IDX_W-1:0]       hit_slot;
    logic [IDX_W-1:0]       idx_slot;
    tlbm_op_e               op;

    assign op       = tlbm_op_e'(cmd_op);
    assign idx_slot = cmd_addr[IDX_LSB +: IDX_W];

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_bits
        assign valid_vec[g] = s_q.data[g][VALID_BIT];
        assign lock_vec[g]  = s_q.data[g][LOCK_BIT];
    end

    tlbm_victim_pick #(.N(NUM_ENTRIES), .IW(IDX_W)) u_victim (
        .valid_vec (valid_vec),
        .lock_vec  (lock_vec),
        .pick_ok   (vic_ok),
        .pick_slot (vic_slot)
    );

    tlbm_tag_match #(.N(NUM_ENTRIES), .W(WORD_W)) u_match (
        .tags      (s_q.tag),
        .valid_vec (valid_vec),
        .key       (cmd_data),
        .hit_vec   (hit_vec)
    );

    tlbm_first_set #(.W(NUM_ENTRIES), .IW(IDX_W)) u_hit_pri (
        .req   (hit_vec),
        .found (hit_found),
        .idx   (hit_slot)
    );

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = cmd_valid;
        s_d.rsp_ok    = 1'b0;
        s_d.rsp_data  = '0;
        s_d.rsp_slot  = '0;
        s_d.rsp_op    = cmd_op;
        if (cmd_valid) begin
            case (op)
                OP_LOAD_TAG: begin
                    s_d.tacc   = cmd_data;
                    s_d.rsp_ok = 1'b1;
                end
                OP_INSERT: begin
                    if (vic_ok) begin
                        s_d.tag[vic_slot]  = s_q.tacc;
                        s_d.data[vic_slot] = cmd_data;
                        s_d.rsp_ok         = 1'b1;
                        s_d.rsp_slot       = vic_slot;
                    end
                end
                OP_WRITE_IDX: begin
                    s_d.tag[idx_slot]  = s_q.tacc;
                    s_d.data[idx_slot] = cmd_data;
                    s_d.rsp_ok         = 1'b1;
                    s_d.rsp_slot       = idx_slot;
                end
                OP_SEARCH: begin
                    if (hit_found) begin
                        s_d.rsp_ok   = 1'b1;
                        s_d.rsp_data = s_q.tag[hit_slot];
                        s_d.rsp_slot = hit_slot;
                    end
                end
                OP_CLEAR: begin
                    for (int i = 0; i < NUM_ENTRIES; i++) begin
                        s_d.data[i][VALID_BIT] = 1'b0;
                    end
                    s_d.rsp_ok = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_valid = s_q.rsp_valid;
    assign rsp_ok    = s_q.rsp_ok;
    assign rsp_data  = s_q.rsp_data;
    assign rsp_slot  = s_q.rsp_slot;

    // ---------------- assertions ----------------
    assert_rsp_follows_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid);

    assert_no_spurious_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rsp_valid);

    assert_insert_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd1 && !(&valid_vec)) |=> rsp_ok);

    assert_insert_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd1 && (&(valid_vec & lock_vec)))
        |=> (!rsp_ok && s_q.data == $past(s_q.data) && s_q.tag == $past(s_q.tag)));

    assert_index_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd2)
        |=> (s_q.data[$past(idx_slot)] == $past(cmd_data)
             && s_q.tag[$past(idx_slot)] == $past(s_q.tacc)));

    assert_hit_is_valid_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && s_q.rsp_op == 3'd3 && rsp_ok)
        |-> (valid_vec[rsp_slot] && s_q.tag[rsp_slot] == rsp_data));

    assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && s_q.rsp_op == 3'd3 && !rsp_ok) |-> (rsp_data == '0 && rsp_slot == '0));

    assert_clear_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd4) |=> (valid_vec == '0 && s_q.tacc == $past(s_q.tacc)));

endmodule

// File: tb/tb_tlbm_entry_mgr.sv
module tb_tlbm_entry_mgr;
    localparam int N  = 8;
    localparam int W  = 16;
    localparam int AW = 16;
    localparam int VB = 15;
    localparam int LB = 6;
    localparam int IL = 3;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [W-1:0]  cmd_data = '0;
    logic          rsp_valid;
    logic          rsp_ok;
    logic [W-1:0]  rsp_data;
    logic [IW-1:0] rsp_slot;

    int n_chk = 0;
    int n_bad = 0;

    logic [W-1:0] m_tag  [N];
    logic [W-1:0] m_data [N];
    logic [W-1:0] m_tacc;

    always #5 clk = ~clk;

    tlbm_entry_mgr #(
        .NUM_ENTRIES(N), .WORD_W(W), .ADDR_W(AW),
        .VALID_BIT(VB), .LOCK_BIT(LB), .IDX_LSB(IL)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rsp_valid(rsp_valid),
        .rsp_ok(rsp_ok), .rsp_data(rsp_data), .rsp_slot(rsp_slot)
    );

    task automatic check(input string req, input logic [W+IW+1:0] act, input logic [W+IW+1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one command, update the model, and compare the response.
    task automatic cmd(input logic [2:0] op, input logic [AW-1:0] a, input logic [W-1:0] d, input string req);
        logic          e_ok   = 1'b0;
        logic [W-1:0]  e_data = '0;
        logic [IW-1:0] e_slot = '0;
        logic          done   = 1'b0;
        case (op)
            3'd0: begin m_tacc = d; e_ok = 1'b1; end
            3'd1: begin
                for (int i = 0; i < N; i++)
                    if (!done && !m_data[i][VB]) begin done = 1'b1; e_slot = IW'(i); end
                for (int i = 0; i < N; i++)
                    if (!done && !m_data[i][LB]) begin done = 1'b1; e_slot = IW'(i); end
                if (done) begin m_tag[e_slot] = m_tacc; m_data[e_slot] = d; e_ok = 1'b1; end
            end
            3'd2: begin
                e_slot = a[IL +: IW];
                m_tag[e_slot] = m_tacc; m_data[e_slot] = d; e_ok = 1'b1;
            end
            3'd3: begin
                for (int i = 0; i < N; i++)
                    if (!done && m_data[i][VB] && m_tag[i] == d) begin
                        done = 1'b1; e_slot = IW'(i); e_data = m_tag[i]; e_ok = 1'b1;
                    end
            end
            3'd4: begin
                for (int i = 0; i < N; i++) m_data[i][VB] = 1'b0;
                e_ok = 1'b1;
            end
            default: ;
        endcase
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(req, {rsp_valid, rsp_ok, rsp_data, rsp_slot}, {1'b1, e_ok, e_data, e_slot});
    endtask

    task automatic idle_check();
        @(negedge clk);
        check("R9 idle", {1'b0, rsp_valid, {(W+IW){1'b0}}}, '0);
    endtask

    task automatic sweep_search(input string req);
        for (int i = 0; i < N; i++) cmd(3'd3, '0, m_tag[i], req);
        cmd(3'd3, '0, 16'hDEAD, req);
    endtask

    function automatic logic [W-1:0] entry(input logic v, input logic l, input int k);
        entry = W'(k) & 16'h3F3F;
        entry[VB] = v;
        entry[LB] = l;
    endfunction

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_tag[i] = '0; m_data[i] = '0; end
        m_tacc = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: nothing valid, tag register zero
        check("R1 reset rsp", {1'b0, rsp_valid, {(W+IW){1'b0}}}, '0);
        cmd(3'd3, '0, 16'h0000, "R1 R8 search zero after reset");
        cmd(3'd1, '0, entry(1'b1, 1'b0, 1), "R1 R3 insert into empty");
        cmd(3'd3, '0, 16'h0000, "R1 tag register was zero");
        cmd(3'd4, '0, '0, "R10 clear");
        // R2 R3: fill every slot with distinct tags
        for (int i = 0; i < N; i++) begin
            cmd(3'd0, '0, 16'h1000 + 16'(i * 17), "R2 load tag");
            cmd(3'd1, '0, entry(1'b1, 1'b0, i), "R3 fill lowest invalid");
        end
        sweep_search("R7 search filled");
        // R4: lock the low half, insert falls to first unlocked
        for (int i = 0; i < N / 2; i++) begin
            cmd(3'd0, '0, 16'h2000 + 16'(i), "R2 load tag");
            cmd(3'd2, AW'(i << IL), entry(1'b1, 1'b1, i), "R6 lock via index");
        end
        cmd(3'd0, '0, 16'h3333, "R2 load tag");
        cmd(3'd1, '0, entry(1'b1, 1'b0, 9), "R4 first unlocked");
        cmd(3'd1, '0, entry(1'b1, 1'b1, 9), "R4 next unlocked");
        // R3 over R4: invalid slot wins over unlocked ones
        cmd(3'd2, AW'(16'hFF00 | (6 << IL) | 3'b101), entry(1'b0, 1'b1, 2), "R6 high bits ignored");
        cmd(3'd1, '0, entry(1'b1, 1'b1, 3), "R3 invalid preferred");
        // R5: lock everything, then insert is dropped
        for (int i = 0; i < N; i++)
            cmd(3'd2, AW'(i << IL), entry(1'b1, 1'b1, i + 4), "R6 lock all");
        cmd(3'd0, '0, 16'h7777, "R2 load tag");
        cmd(3'd1, '0, entry(1'b1, 1'b0, 5), "R5 full and locked");
        cmd(3'd3, '0, 16'h7777, "R5 no entry with new tag");
        sweep_search("R7 after lock");
        // R7: duplicate tag, lowest slot wins; invalid slot never matches
        cmd(3'd0, '0, 16'h4444, "R2 load tag");
        cmd(3'd2, AW'(5 << IL), entry(1'b1, 1'b1, 1), "R6 dup high");
        cmd(3'd2, AW'(2 << IL), entry(1'b1, 1'b0, 1), "R6 dup low");
        cmd(3'd3, '0, 16'h4444, "R7 lowest duplicate");
        cmd(3'd2, AW'(2 << IL), entry(1'b0, 1'b0, 1), "R6 invalidate low");
        cmd(3'd3, '0, 16'h4444, "R7 invalid skipped");
        cmd(3'd2, AW'(5 << IL), entry(1'b0, 1'b0, 1), "R6 invalidate high");
        cmd(3'd3, '0, 16'h4444, "R8 miss invalid tag");
        // R9: unused codes change nothing; idle has no response
        cmd(3'd5, '0, 16'hFFFF, "R9 unused code");
        cmd(3'd7, AW'(1 << IL), 16'hFFFF, "R9 unused code");
        idle_check();
        sweep_search("R9 table unchanged");
        // R10: clear drops all, keeps tag register
        cmd(3'd4, '0, '0, "R10 clear");
        sweep_search("R10 all miss");
        cmd(3'd1, '0, entry(1'b1, 1'b1, 6), "R10 insert lands at 0");
        cmd(3'd3, '0, 16'h4444, "R10 R2 tag register kept");
        idle_check();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule